// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block gathers one-cycle event pulses from an I2C controller-side engine and an I2C target-side engine and turns them into interrupt requests. Each side has its own set of three registers. A sticky raw status register records every event. A mask register enables sources, and a bit left at zero disables its source. A read-only masked view holds the raw bits ANDed with the mask. Software acknowledges events by writing ones to a per-side clear register. Each side drives its own interrupt line, which is high when any enabled raw bit is set.

Several causes share one status bit:
- On the controller side, transaction-complete and next-byte-request both set raw bit 0. The next-byte cause fires when a receive or transmit transaction is requested.
- On the target side, data-received, data-requested and next-byte-request all set raw bit 0.

The two sides share no state. Register access uses a plain synchronous bus: a write takes effect on the clock edge where `bus_we` is high, and `bus_rdata` is a combinational decode of `bus_addr`.

Top module: `i2c_irq_status`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every mask and raw bit on both sides is zero, and both interrupt outputs are low.
- R2: Controller event input bits map to raw status bits as follows.
  - Input bits 0 (transaction complete) and 1 (next-byte request) both set raw bit 0.
  - Input bit k, for k from 2 to 12, sets raw bit k-1. In order these are: arbitration lost, address/data NACK, clock time-out, START seen, STOP seen, RX DMA pending, TX DMA pending, TX FIFO trigger, RX FIFO trigger, TX FIFO empty, RX FIFO full.
- R3: Target event input bits map to raw status bits as follows.
  - Input bits 0 (received), 1 (requested) and 2 (next byte) all set raw bit 0.
  - Input bit k, for k from 3 to 10, sets raw bit k-2. In order these are: START seen, STOP seen, RX DMA pending, TX DMA pending, TX trigger, RX trigger, TX FIFO empty, RX FIFO full.
- R4: A raw bit set by a pulse stays set until software clears it.
- R5: Writing to a side's clear register clears the raw bits where the write data holds ones. Bits where the write data holds zeros are left unchanged.
- R6: When an event and a clear write reach the same raw bit on the same edge, the bit ends up set.
- R7: Writing the mask register loads it. The masked status reads as raw AND mask.
- R8: Each interrupt output is registered. It equals the OR of that side's masked status as it stood one clock earlier.
- R9: Register writes and events on one side never change the other side's registers or interrupt.
- R10: The word address map is:

  | Address | Register |
  |---------|----------|
  | 0 | controller mask |
  | 1 | controller raw |
  | 2 | controller masked |
  | 3 | controller clear |
  | 4 | target mask |
  | 5 | target raw |
  | 6 | target masked |
  | 7 | target clear |

  Register values occupy the low data bits. Clear addresses read zero. Addresses 8 and above read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_evt | input | 13 | Controller-side event pulses, one cycle each |
| slv_evt | input | 11 | Target-side event pulses, one cycle each |
| bus_addr | input | ADDR_W (4) | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| mst_irq | output | 1 | Controller-side interrupt |
| slv_irq | output | 1 | Target-side interrupt |

## Verification
The bench builds the block with its defaults, ADDR_W = 4 and DATA_W = 32. A four-bit address puts eight unmapped words (8 to 15) within reach, so the test can check ignored writes and zero reads there. The 32-bit data path leaves upper bits above both raw widths; these are shown to read back as zero. Every single and shared event input is driven through a vector table against both raw registers. The set-versus-clear collision and the one-cycle interrupt lag after mask changes are timed at exact edges.

// File: rtl/i2c_irq_pkg.sv
// Package: shared widths and register word indices for the I2C interrupt status unit.
// Assumes: the event vectors list shared causes first, at the low indices.
package i2c_irq_pkg;
    localparam int MST_IN_W   = 13;
    localparam int MST_SHARED = 2;
    localparam int MST_RAW_W  = MST_IN_W - MST_SHARED + 1;
    localparam int SLV_IN_W   = 11;
    localparam int SLV_SHARED = 3;
    localparam int SLV_RAW_W  = SLV_IN_W - SLV_SHARED + 1;
    localparam int IDX_W      = 3;

    typedef enum logic [IDX_W-1:0] {
        REG_M_MASK = 3'd0,
        REG_M_RAW  = 3'd1,
        REG_M_MIS  = 3'd2,
        REG_M_CLR  = 3'd3,
        REG_S_MASK = 3'd4,
        REG_S_RAW  = 3'd5,
        REG_S_MIS  = 3'd6,
        REG_S_CLR  = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/irq_event_fold.sv
// Module: irq_event_fold
// Folds a vector of event pulses into raw-status set bits. The low SHARED inputs
// are ORed into set bit 0; each further input passes straight to its own bit.
// Assumes: SHARED >= 1 and IN_W > SHARED.
module irq_event_fold #(
    parameter int IN_W   = 13,
    parameter int SHARED = 2,
    localparam int OUT_W = IN_W - SHARED + 1
) (
    input  logic [IN_W-1:0]  evt_i,
    output logic [OUT_W-1:0] set_o
);
    // Shared causes collapse to one status bit
    assign set_o[0] = |evt_i[SHARED-1:0];

    // Dedicated causes keep their order
    for (genvar g = 1; g < OUT_W; g++) begin : g_pass
        assign set_o[g] = evt_i[g + SHARED - 1];
    end
endmodule

// File: rtl/irq_side.sv
// Module: irq_side
// One side's interrupt state: sticky raw bits, mask register, masked view and a
// registered interrupt line. A set event beats a same-cycle clear.
// Assumes: set_i bits are single-cycle pulses; write strobes are pre-decoded.
module irq_side #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         wr_mask_i,
    input  logic         wr_clr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] masked_o,
    output logic         irq_o
);
    logic [N-1:0] raw_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] clr_vec;
    logic         irq_q;

    // Clear vector is active only on a clear-register write
    assign clr_vec = wr_clr_i ? wdata_i : '0;

    // Raw status: clear first, then OR in new events so the set wins
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_vec) | set_i;
    end

    // Mask register load
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (wr_mask_i) mask_q <= wdata_i;
    end

    // Interrupt line registered from the current masked view
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(raw_q & mask_q);
    end

    assign raw_o    = raw_q;
    assign mask_o   = mask_q;
    assign masked_o = raw_q & mask_q;
    assign irq_o    = irq_q;

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_clr_i) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr_i && set_i == '0) |=> ((raw_q & $past(wdata_i)) == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((raw_q & $past(set_i)) == $past(set_i)));

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_i |=> (mask_q == $past(wdata_i)));

    assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_q == |($past(raw_q) & $past(mask_q))));
endmodule

// File: rtl/i2c_irq_regbus.sv
// Module: i2c_irq_regbus
// Decodes the register bus: produces per-side write strobes and the read mux.
// Assumes: ADDR_W > IDX_W; words at and above 2**IDX_W are unmapped.
module i2c_irq_regbus
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int M_W    = 12,
    parameter int S_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [M_W-1:0]    m_mask_i,
    input  logic [M_W-1:0]    m_raw_i,
    input  logic [M_W-1:0]    m_mis_i,
    input  logic [S_W-1:0]    s_mask_i,
    input  logic [S_W-1:0]    s_raw_i,
    input  logic [S_W-1:0]    s_mis_i,
    output logic              m_wr_mask_o,
    output logic              m_wr_clr_o,
    output logic              s_wr_mask_o,
    output logic              s_wr_clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic     hit;
    reg_idx_e idx;

    // Only the low word block is mapped
    assign hit = (addr_i[ADDR_W-1:IDX_W] == '0);
    assign idx = reg_idx_e'(addr_i[IDX_W-1:0]);

    // Write strobes
    assign m_wr_mask_o = we_i && hit && (idx == REG_M_MASK);
    assign m_wr_clr_o  = we_i && hit && (idx == REG_M_CLR);
    assign s_wr_mask_o = we_i && hit && (idx == REG_S_MASK);
    assign s_wr_clr_o  = we_i && hit && (idx == REG_S_CLR);

    // Read mux, zero-extended; clear words and unmapped words read zero
    always_comb begin
        rdata_o = '0;
        if (hit) begin
            case (idx)
                REG_M_MASK: rdata_o[M_W-1:0] = m_mask_i;
                REG_M_RAW:  rdata_o[M_W-1:0] = m_raw_i;
                REG_M_MIS:  rdata_o[M_W-1:0] = m_mis_i;
                REG_S_MASK: rdata_o[S_W-1:0] = s_mask_i;
                REG_S_RAW:  rdata_o[S_W-1:0] = s_raw_i;
                REG_S_MIS:  rdata_o[S_W-1:0] = s_mis_i;
                default:    rdata_o = '0;
            endcase
        end
    end

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_wr_mask_o, m_wr_clr_o, s_wr_mask_o, s_wr_clr_o}));

    assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |-> ({m_wr_mask_o, m_wr_clr_o, s_wr_mask_o, s_wr_clr_o} == 4'b0));
endmodule

// File: rtl/i2c_irq_status.sv
// Module: i2c_irq_status (top)
// Interrupt status unit for an I2C controller/target pair: folds event pulses,
// keeps two independent register sets and drives one interrupt line per side.
// Assumes: event inputs are one-cycle pulses synchronous to clk; DATA_W >= 12.
module i2c_irq_status
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MST_IN_W-1:0]  mst_evt,
    input  logic [SLV_IN_W-1:0]  slv_evt,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 mst_irq,
    output logic                 slv_irq
);
    logic [MST_RAW_W-1:0] m_set, m_raw, m_mask, m_mis;
    logic [SLV_RAW_W-1:0] s_set, s_raw, s_mask, s_mis;
    logic m_wr_mask, m_wr_clr, s_wr_mask, s_wr_clr;

    irq_event_fold #(.IN_W(MST_IN_W), .SHARED(MST_SHARED)) u_m_fold (
        .evt_i(mst_evt), .set_o(m_set));

    irq_event_fold #(.IN_W(SLV_IN_W), .SHARED(SLV_SHARED)) u_s_fold (
        .evt_i(slv_evt), .set_o(s_set));

    i2c_irq_regbus #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .M_W(MST_RAW_W), .S_W(SLV_RAW_W)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .we_i(bus_we),
        .m_mask_i(m_mask), .m_raw_i(m_raw), .m_mis_i(m_mis),
        .s_mask_i(s_mask), .s_raw_i(s_raw), .s_mis_i(s_mis),
        .m_wr_mask_o(m_wr_mask), .m_wr_clr_o(m_wr_clr),
        .s_wr_mask_o(s_wr_mask), .s_wr_clr_o(s_wr_clr),
        .rdata_o(bus_rdata));

    irq_side #(.N(MST_RAW_W)) u_m_side (
        .clk(clk), .rst_n(rst_n), .set_i(m_set),
        .wr_mask_i(m_wr_mask), .wr_clr_i(m_wr_clr), .wdata_i(bus_wdata[MST_RAW_W-1:0]),
        .raw_o(m_raw), .mask_o(m_mask), .masked_o(m_mis), .irq_o(mst_irq));

    irq_side #(.N(SLV_RAW_W)) u_s_side (
        .clk(clk), .rst_n(rst_n), .set_i(s_set),
        .wr_mask_i(s_wr_mask), .wr_clr_i(s_wr_clr), .wdata_i(bus_wdata[SLV_RAW_W-1:0]),
        .raw_o(s_raw), .mask_o(s_mask), .masked_o(s_mis), .irq_o(slv_irq));

    // Side isolation: a write to one side's registers leaves the other side's mask alone
    assert_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr_mask || m_wr_clr) |=> $stable(s_mask));
endmodule

// File: tb/i2c_irq_status_bench.sv
// Bench for i2c_irq_status: a vector table for event mapping, then directed tests.
module i2c_irq_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [12:0]       mst_evt = '0;
    logic [10:0]       slv_evt = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              mst_irq, slv_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DATA_W-1:0] rd;

    i2c_irq_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_i2c_irq_status (
        .clk(clk), .rst_n(rst_n), .mst_evt(mst_evt), .slv_evt(slv_evt),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mst_irq(mst_irq), .slv_irq(slv_irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [12:0] m_in;
        logic [10:0] s_in;
        logic [11:0] m_exp;
        logic [8:0]  s_exp;
    } vec_t;

    // Event mapping vectors (R2 controller side, R3 target side)
    localparam vec_t VEC [10] = '{
        '{13'h0001, 11'h000, 12'h001, 9'h000},
        '{13'h0002, 11'h000, 12'h001, 9'h000},
        '{13'h0003, 11'h000, 12'h001, 9'h000},
        '{13'h1000, 11'h000, 12'h800, 9'h000},
        '{13'h1FFC, 11'h000, 12'hFFE, 9'h000},
        '{13'h0000, 11'h001, 12'h000, 9'h001},
        '{13'h0000, 11'h002, 12'h000, 9'h001},
        '{13'h0000, 11'h004, 12'h000, 9'h001},
        '{13'h0000, 11'h7F8, 12'h000, 9'h1FE},
        '{13'h0010, 11'h008, 12'h008, 9'h002}
    };

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [12:0] m, input logic [10:0] s);
        @(negedge clk);
        mst_evt = m; slv_evt = s;
        @(negedge clk);
        mst_evt = '0; slv_evt = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every mapped word and both interrupt lines
        for (int a = 0; a < 8; a++) begin
            bus_read(ADDR_W'(a), rd);
            check("R1", rd, '0);
        end
        check("R1", {31'b0, mst_irq}, '0);
        check("R1", {31'b0, slv_irq}, '0);

        // R2/R3: vector table walk
        for (int i = 0; i < 10; i++) begin
            bus_write(4'd3, '1);
            bus_write(4'd7, '1);
            pulse(VEC[i].m_in, VEC[i].s_in);
            bus_read(4'd1, rd);
            check("R2", rd, {20'b0, VEC[i].m_exp});
            bus_read(4'd5, rd);
            check("R3", rd, {23'b0, VEC[i].s_exp});
        end
        bus_write(4'd3, '1);
        bus_write(4'd7, '1);

        // R4: arbitration lost (in bit 2 -> raw bit 1) stays set
        pulse(13'h0004, '0);
        repeat (3) @(negedge clk);
        bus_read(4'd1, rd);
        check("R4", rd, 32'h002);

        // R5: zero clear has no effect, one clears
        bus_write(4'd3, 32'h0);
        bus_read(4'd1, rd);
        check("R5", rd, 32'h002);
        bus_write(4'd3, 32'h002);
        bus_read(4'd1, rd);
        check("R5", rd, 32'h000);

        // R6: set and clear on the same edge; START (in 5 -> raw 4) preset
        pulse(13'h0020, '0);
        @(negedge clk);
        bus_addr = 4'd3; bus_wdata = '1; bus_we = 1'b1; mst_evt = 13'h0004;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; mst_evt = '0;
        bus_read(4'd1, rd);
        check("R6", rd, 32'h002);

        // R7/R8: mask raw bit 1, masked view and one-cycle irq lag
        bus_write(4'd3, '1);
        bus_write(4'd0, 32'h002);
        bus_read(4'd0, rd);
        check("R7", rd, 32'h002);
        @(negedge clk);
        mst_evt = 13'h0004;
        @(negedge clk);
        mst_evt = '0;
        check("R8", {31'b0, mst_irq}, '0);
        @(negedge clk);
        check("R8", {31'b0, mst_irq}, 32'h1);
        bus_read(4'd2, rd);
        check("R7", rd, 32'h002);
        // Unmasked source sets raw but not the masked view
        pulse(13'h0008, '0);
        bus_read(4'd1, rd);
        check("R7", rd, 32'h006);
        bus_read(4'd2, rd);
        check("R7", rd, 32'h002);
        // Mask drop: irq still high right after the write edge, low one cycle later
        bus_write(4'd0, 32'h0);
        check("R8", {31'b0, mst_irq}, 32'h1);
        @(negedge clk);
        check("R8", {31'b0, mst_irq}, '0);

        // R9: target side untouched by controller writes and events
        pulse('0, 11'h010);
        bus_write(4'd4, 32'h004);
        bus_write(4'd3, '1);
        bus_write(4'd0, '1);
        pulse(13'h1FFF, '0);
        bus_read(4'd5, rd);
        check("R9", rd, 32'h004);
        bus_read(4'd4, rd);
        check("R9", rd, 32'h004);
        check("R9", {31'b0, slv_irq}, 32'h1);
        bus_write(4'd7, '1);
        bus_read(4'd1, rd);
        check("R9", rd, 32'hFFF);

        // Target irq through shared bit 0 (requested cause)
        bus_write(4'd4, 32'h001);
        pulse('0, 11'h002);
        @(negedge clk);
        check("R8", {31'b0, slv_irq}, 32'h1);

        // R10: clear words read zero, unmapped words ignored
        bus_read(4'd3, rd);
        check("R10", rd, '0);
        bus_read(4'd7, rd);
        check("R10", rd, '0);
        bus_write(4'd8, '1);
        bus_write(4'd12, '1);
        bus_read(4'd8, rd);
        check("R10", rd, '0);
        bus_read(4'd0, rd);
        check("R10", rd, 32'hFFF);
        bus_read(4'd4, rd);
        check("R10", rd, 32'h001);
        bus_read(4'd1, rd);
        check("R10", rd, 32'hFFF);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(4'd1, rd);
        check("R1", rd, '0);
        bus_read(4'd4, rd);
        check("R1", rd, '0);
        check("R1", {30'b0, mst_irq, slv_irq}, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule